// File: doc/BRIEF.md
# Running Sign-Clustered EVM Estimator

This block keeps a running estimate of error vector magnitude for a stream of I/Q samples taken once per symbol. Each accepted sample is first rotated by a programmable angle, supplied as its cosine and sine, to cancel a constant phase offset such as the one a compressing power amplifier introduces. The rotated point is then placed in one of four quadrant clusters according to the signs of its components.

The ideal points are not fixed in advance. Each one is learned as the centre of gravity of its cluster over a sliding window of the most recent symbols. The block keeps only per-cluster counts, first-moment sums and one total of squared magnitudes, and removes the oldest symbol's share as each new symbol arrives. From these moments it forms the squared error power relative to the centroid power. It reports that ratio as EVM squared in unsigned Q1.15, so no square root is needed. It also flags whether the value is within the 35 % compliance limit, which is 0.1225 when squared.

Samples arrive on a valid/ready stream. After a handshake the input stays closed while the estimate is computed and until the estimate has been taken on the output valid/ready stream. A producer therefore sees back-pressure for the whole computation plus any time the consumer holds the output. A producer may hold its sample valid for as long as it likes. The output holds its valid and its data unchanged until it is taken.

Top module: `evm_estimator`

## Requirements
- R1: `s_ready` is high only when no estimate is being computed or waiting to be taken. A sample is taken only on a clock edge with `s_valid` and `s_ready` both high. A sample driven while `s_ready` is low has no effect on any later estimate, and `s_ready` returns high in the cycle after the output is taken.
- R2: With C = `rot_cos` and S = `rot_sin` as signed Q2.14 values (16384 = 1.0), the rotated point is Ir = (I·C − Q·S) >>> 14 and Qr = (I·S + Q·C) >>> 14, using arithmetic (floor) shifts. With C = 16384 and S = 0 the point passes through unchanged.
- R3: The cluster index is 2·(Qr < 0) + (Ir < 0). A component that is exactly zero counts as positive.
- R4: An estimate covers only the last DEPTH accepted samples (DEPTH is a power of two, 256 by default). Once DEPTH samples are held, each new sample evicts the oldest one.
- R5: For each cluster k holding N_k > 0 samples, with component sums SI_k and SQ_k, let R = Σ floor((SI_k² + SQ_k²)/N_k). Let E = (Σ of Ir² + Qr² over the window) − R. The estimate is 0 when R = 0, 32767 when E ≥ R, and floor(E·2^15/R) otherwise.
- R6: Exactly one estimate is produced per accepted sample. `m_valid` and `m_evm_sq` stay unchanged while `m_ready` is low, and `m_valid` falls in the cycle after the handshake.
- R7: `m_settled` is low with the first DEPTH−1 estimates after reset. It is high from the DEPTH-th estimate on and stays high until reset.
- R8: After reset `s_ready` is 1, `m_valid` is 0, `m_settled` is 0 and the window is empty.
- R9: `m_within` is high exactly when `m_evm_sq` ≤ LIMIT (default 4014, the Q1.15 value of 0.35²).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Symbol sample valid (symbol strobe) |
| s_ready | output | 1 | Block can take a sample |
| s_i | input | DW | Signed in-phase sample |
| s_q | input | DW | Signed quadrature sample |
| rot_cos | input | CW | Cosine of compensation angle, signed Q2.14 |
| rot_sin | input | CW | Sine of compensation angle, signed Q2.14 |
| m_valid | output | 1 | Estimate available |
| m_ready | input | 1 | Consumer takes the estimate |
| m_evm_sq | output | 16 | EVM squared, unsigned Q1.15 |
| m_settled | output | 1 | Window has been full; estimate is final rather than provisional |
| m_within | output | 1 | Estimate is within the compliance limit |

## Verification
The assertions assume that reset is applied before the first sample. They assume `m_ready` may stay low for any number of cycles, and that `s_valid` may be held high while the block is busy. The divider checks take for granted that the controller never starts a division with a zero divisor, since empty clusters and zero centroid power are skipped. The stimulus changes `rot_cos` and `rot_sin` only between samples. It deliberately drives junk samples while `s_ready` is low and holds `m_ready` low for two cycles on every estimate. Inputs stay within DW bits, so the rotated point always fits the widened internal width.

// File: rtl/evm_pkg.sv
package evm_pkg;
  localparam int QB = 15;
  localparam logic [15:0] EVM_SAT = 16'h7FFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLU,
    ST_WAITK,
    ST_FIN,
    ST_WAITF,
    ST_OUT
  } evm_state_e;
endpackage

// File: rtl/evm_iq_rotate.sv
module evm_iq_rotate #(
  parameter int DW   = 12,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int RW   = 15
) (
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic signed [CW-1:0] c,
  input  logic signed [CW-1:0] s,
  output logic signed [RW-1:0] out_i,
  output logic signed [RW-1:0] out_q
);
  localparam int PW = DW + CW + 1;

  logic signed [PW-1:0] acc_i, acc_q;

  always_comb begin
    acc_i = PW'(in_i) * PW'(c) - PW'(in_q) * PW'(s);
    acc_q = PW'(in_i) * PW'(s) + PW'(in_q) * PW'(c);
    out_i = RW'(acc_i >>> FRAC);
    out_q = RW'(acc_q >>> FRAC);
  end
endmodule

// File: rtl/evm_window.sv
module evm_window #(
  parameter int EW    = 30,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [EW-1:0] wdata,
  output logic [EW-1:0] rdata,
  output logic [AW-1:0] ptr,
  output logic          filled
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      filled <= 1'b0;
    end else if (we) begin
      ptr <= ptr + 1'b1;
      if (ptr == AW'(DEPTH - 1)) filled <= 1'b1;
    end
  end

  assign rdata = mem[ptr];
endmodule

// File: rtl/evm_serial_div.sv
module evm_serial_div #(
  parameter int NW = 53,
  parameter int DW = 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CNW = $clog2(NW + 1);

  logic [DW-1:0]  rem, den_q, diff;
  logic [DW:0]    sh;
  logic [CNW-1:0] cnt;
  logic           ge;

  always_comb begin
    sh   = {rem, quo[NW-1]};
    ge   = sh >= {1'b0, den_q};
    diff = DW'(sh - {1'b0, den_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        quo   <= num;
        den_q <= den;
        cnt   <= CNW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem <= ge ? diff : sh[DW-1:0];
        quo <= {quo[NW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CNW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5: the controller never divides by zero
  assert_den_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> den != '0);

  // R5: partial remainder stays below the divisor throughout the division
  assert_rem_below_den_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem < den_q);
endmodule

// File: rtl/evm_estimator.sv
module evm_estimator
  import evm_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 16,
  parameter int DEPTH = 256,
  parameter int LIMIT = 4014
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [DW-1:0] s_q,
  input  logic signed [CW-1:0] rot_cos,
  input  logic signed [CW-1:0] rot_sin,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [15:0]          m_evm_sq,
  output logic                 m_settled,
  output logic                 m_within
);
  localparam int FRAC = CW - 2;
  localparam int RW   = DW + 3;
  localparam int AW   = $clog2(DEPTH);
  localparam int NCW  = AW + 1;
  localparam int SW   = RW + AW;
  localparam int SQW  = 2 * RW;
  localparam int S2W  = SQW + AW;
  localparam int MAGW = 2 * SW;
  localparam int DENW = S2W;
  localparam int NUMW = (MAGW > S2W + QB) ? MAGW : S2W + QB;

  evm_state_e st;
  logic [1:0] k;
  logic       accept;

  logic signed [RW-1:0] rot_i, rot_q, old_i, old_q;
  logic [1:0]           new_cl, old_cl;
  logic [2*RW-1:0]      old_word;
  logic [AW-1:0]        ptr;
  logic                 filled;
  logic signed [SQW-1:0] p_ni, p_nq, p_oi, p_oq;
  logic [SQW-1:0]       new_sq, old_sq;

  logic [NCW-1:0]       cnt   [4];
  logic signed [SW-1:0] sum_i [4];
  logic signed [SW-1:0] sum_q [4];
  logic [S2W-1:0]       s2, racc, err;
  logic signed [MAGW-1:0] ext_i, ext_q;
  logic [MAGW-1:0]      mag_k;
  logic [15:0]          est;

  logic            div_start, div_busy, div_done;
  logic [NUMW-1:0] div_num, div_quo;
  logic [DENW-1:0] div_den;

  assign s_ready = (st == ST_IDLE);
  assign accept  = s_valid && s_ready;

  evm_iq_rotate #(.DW(DW), .CW(CW), .FRAC(FRAC), .RW(RW)) u_rot (
    .in_i(s_i), .in_q(s_q), .c(rot_cos), .s(rot_sin),
    .out_i(rot_i), .out_q(rot_q)
  );

  evm_window #(.EW(2 * RW), .DEPTH(DEPTH), .AW(AW)) u_win (
    .clk(clk), .rst_n(rst_n), .we(accept), .wdata({rot_i, rot_q}),
    .rdata(old_word), .ptr(ptr), .filled(filled)
  );

  always_comb begin
    old_i  = $signed(old_word[2*RW-1:RW]);
    old_q  = $signed(old_word[RW-1:0]);
    new_cl = {rot_q[RW-1], rot_i[RW-1]};
    old_cl = {old_q[RW-1], old_i[RW-1]};
    p_ni   = SQW'(rot_i) * SQW'(rot_i);
    p_nq   = SQW'(rot_q) * SQW'(rot_q);
    p_oi   = SQW'(old_i) * SQW'(old_i);
    p_oq   = SQW'(old_q) * SQW'(old_q);
    new_sq = p_ni + p_nq;
    old_sq = p_oi + p_oq;
  end

  // Per-cluster moment accumulators: add the newcomer, drop the evicted one
  for (genvar g = 0; g < 4; g++) begin : g_clu
    logic                 add_g, sub_g;
    logic [NCW-1:0]       cnt_r;
    logic signed [SW-1:0] si_r, sq_r;

    assign add_g = (new_cl == 2'(g));
    assign sub_g = filled && (old_cl == 2'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_r <= '0;
        si_r  <= '0;
        sq_r  <= '0;
      end else if (accept) begin
        cnt_r <= cnt_r + NCW'(add_g) - NCW'(sub_g);
        si_r  <= si_r + (add_g ? SW'(rot_i) : '0) - (sub_g ? SW'(old_i) : '0);
        sq_r  <= sq_r + (add_g ? SW'(rot_q) : '0) - (sub_g ? SW'(old_q) : '0);
      end
    end

    assign cnt[g]   = cnt_r;
    assign sum_i[g] = si_r;
    assign sum_q[g] = sq_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2 <= '0;
    else if (accept) s2 <= s2 + S2W'(new_sq) - (filled ? S2W'(old_sq) : '0);
  end

  always_comb begin
    ext_i     = MAGW'(sum_i[k]);
    ext_q     = MAGW'(sum_q[k]);
    mag_k     = ext_i * ext_i + ext_q * ext_q;
    err       = s2 - racc;
    div_start = ((st == ST_CLU) && (cnt[k] != '0)) ||
                ((st == ST_FIN) && (racc != '0) && (err < racc));
    div_num   = (st == ST_FIN) ? (NUMW'(err) << QB) : NUMW'(mag_k);
    div_den   = (st == ST_FIN) ? racc : DENW'(cnt[k]);
  end

  evm_serial_div #(.NW(NUMW), .DW(DENW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      k    <= '0;
      racc <= '0;
      est  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          racc <= '0;
          k    <= '0;
          st   <= ST_CLU;
        end
        ST_CLU: begin
          if (cnt[k] != '0) st <= ST_WAITK;
          else if (k == 2'd3) st <= ST_FIN;
          else k <= k + 1'b1;
        end
        ST_WAITK: if (div_done) begin
          racc <= racc + S2W'(div_quo);
          if (k == 2'd3) st <= ST_FIN;
          else begin
            k  <= k + 1'b1;
            st <= ST_CLU;
          end
        end
        ST_FIN: begin
          if (racc == '0) begin
            est <= '0;
            st  <= ST_OUT;
          end else if (err >= racc) begin
            est <= EVM_SAT;
            st  <= ST_OUT;
          end else st <= ST_WAITF;
        end
        ST_WAITF: if (div_done) begin
          est <= {1'b0, div_quo[QB-1:0]};
          st  <= ST_OUT;
        end
        ST_OUT: if (m_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign m_valid   = (st == ST_OUT);
  assign m_evm_sq  = est;
  assign m_settled = filled;
  assign m_within  = (est <= 16'(LIMIT));

  logic [NCW+1:0] occ;
  assign occ = (NCW+2)'(cnt[0]) + (NCW+2)'(cnt[1]) + (NCW+2)'(cnt[2]) + (NCW+2)'(cnt[3]);

  // R4: cluster populations add up to the number of samples held in the ring
  assert_occupancy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ == (filled ? (NCW+2)'(DEPTH) : (NCW+2)'(ptr)));

  // R6: an offered estimate is held unchanged until taken
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_evm_sq));

  // R1: no sample is taken while the divider is working
  assert_closed_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !s_ready);

  // R7: once settled, the flag never drops before reset
  assert_settled_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_settled |=> m_settled);

  // R2: unit rotation leaves the point untouched
  assert_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_cos == CW'(16384)) && (rot_sin == '0) |-> (rot_i == RW'(s_i)) && (rot_q == RW'(s_q)));
endmodule

// File: tb/evm_estimator_bench.sv
module evm_estimator_bench;
  localparam int DW = 12, CW = 16, DEPTH = 16, LIMIT = 4014;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                 s_valid = 1'b0, m_ready = 1'b0;
  logic                 s_ready, m_valid, m_settled, m_within;
  logic signed [DW-1:0] s_i = '0, s_q = '0;
  logic signed [CW-1:0] rot_cos = 16'sd16384, rot_sin = '0;
  logic [15:0]          m_evm_sq;

  evm_estimator #(.DW(DW), .CW(CW), .DEPTH(DEPTH), .LIMIT(LIMIT)) u_evm_estimator (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .rot_cos(rot_cos), .rot_sin(rot_sin),
    .m_valid(m_valid), .m_ready(m_ready), .m_evm_sq(m_evm_sq),
    .m_settled(m_settled), .m_within(m_within)
  );

  int n_cmp = 0, n_bad = 0, n_acc = 0, seed = 7;
  bit fin = 1'b0;
  longint wi[$], wq[$];

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(int m);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 32767) % m;
  endfunction

  function automatic longint model_est();
    longint si[4], sq[4], n[4], s2, r, e;
    s2 = 0; r = 0;
    for (int c = 0; c < 4; c++) begin si[c] = 0; sq[c] = 0; n[c] = 0; end
    for (int j = 0; j < wi.size(); j++) begin
      int c;
      c = (wq[j] < 0 ? 2 : 0) + (wi[j] < 0 ? 1 : 0);
      si[c] += wi[j]; sq[c] += wq[j]; n[c] += 1;
      s2 += wi[j] * wi[j] + wq[j] * wq[j];
    end
    for (int c = 0; c < 4; c++)
      if (n[c] > 0) r += (si[c] * si[c] + sq[c] * sq[c]) / n[c];
    e = s2 - r;
    if (r == 0) return 0;
    if (e >= r) return 32767;
    return (e <<< 15) / r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    wi.delete(); wq.delete(); n_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(int i, int q, string tag);
    longint c, s, ri, rq, exp;
    logic [15:0] held;
    int t;
    s_i = DW'(i); s_q = DW'(q); s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    c = longint'(rot_cos); s = longint'(rot_sin);
    ri = (longint'(i) * c - longint'(q) * s) >>> 14;
    rq = (longint'(i) * s + longint'(q) * c) >>> 14;
    wi.push_back(ri); wq.push_back(rq);
    if (wi.size() > DEPTH) begin void'(wi.pop_front()); void'(wq.pop_front()); end
    n_acc++;
    exp = model_est();
    // junk sample offered while closed: must be ignored (R1)
    s_i = DW'(-1999); s_q = DW'(1777);
    @(negedge clk);
    chk("R1 ready low while computing", s_ready, 0);
    @(negedge clk);
    s_valid = 1'b0;
    t = 0;
    while (!m_valid && t < 5000) begin @(negedge clk); t++; end
    chk(tag, m_evm_sq, exp);
    chk("R7 settled flag", m_settled, (n_acc >= DEPTH) ? 1 : 0);
    chk("R9 limit flag", m_within, (exp <= LIMIT) ? 1 : 0);
    held = m_evm_sq;
    repeat (2) @(negedge clk);
    chk("R6 valid held", m_valid, 1);
    chk("R6 data held", m_evm_sq, held);
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    chk("R6 single estimate", m_valid, 0);
    chk("R1 ready after take", s_ready, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 ready after reset", s_ready, 1);
    chk("R8 valid after reset", m_valid, 0);
    chk("R8 settled after reset", m_settled, 0);
    send(900, -900, "R8 first sample on empty window");
  endtask

  task automatic t_clean();
    for (int n = 0; n < 8; n++)
      send((n % 2) ? -1000 : 1000, (n % 4 < 2) ? 1000 : -1000, "R5 ideal constellation");
  endtask

  task automatic t_noise();
    for (int n = 0; n < 12; n++)
      send(((n % 2) ? -800 : 800) + rnd(201) - 100,
           ((n % 3) ? 800 : -800) + rnd(201) - 100, "R5 noisy constellation");
  endtask

  task automatic t_zero_axis();
    send(0, 500, "R3 zero I counts positive");
    send(500, 0, "R3 zero Q counts positive");
    send(0, -500, "R3 zero I with negative Q");
    send(-500, 0, "R3 zero Q with negative I");
    send(0, 0, "R3 origin in first cluster");
  endtask

  task automatic t_rotate();
    rot_cos = 16'sd11585; rot_sin = 16'sd11585;
    for (int n = 0; n < 8; n++)
      send((n % 4 == 0) ? 1000 : (n % 4 == 2) ? -1000 : rnd(61) - 30,
           (n % 4 == 1) ? 1000 : (n % 4 == 3) ? -1000 : rnd(61) - 30,
           "R2 rotated samples");
    rot_cos = 16'sd16384; rot_sin = '0;
  endtask

  task automatic t_fill();
    for (int n = 0; n < DEPTH + 10; n++)
      send(((n % 2) ? -600 : 600) + rnd(301) - 150,
           ((n % 5 < 2) ? 600 : -600) + rnd(301) - 150, "R4 sliding window");
  endtask

  task automatic t_saturate();
    do_reset();
    chk("R8 settled cleared by reset", m_settled, 0);
    send(0, 0, "R5 zero centroid power gives 0");
    send(2000, 2000, "R5 error at least centroid power saturates");
    chk("R5 saturated code", m_evm_sq, 32767);
    chk("R9 saturated is outside limit", m_within, 0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_noise();
    t_zero_axis();
    t_rotate();
    t_fill();
    t_saturate();
    if (!fin) begin
      fin = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule